// File: doc/BRIEF.md
# Dual-Source Timer Prescaler with Staged Register Writes

This block is the clocking and counting core of an 8-bit timer whose time base is either the system clock or a separate slow oscillator clock. A source-select input picks which clock drives the timer domain. Inside that domain a free-running 10-bit divider produces a count enable. A 3-bit select code chooses the enable: stopped, every timer clock, or one of six divided rates. The enable advances an 8-bit counter.

The CPU side runs on the system clock. Writes to the select code and to the count value do not reach the timer domain directly. Each write is held in a staging register and crossed over with a toggle request and an acknowledge. A per-register busy output stays high until the acknowledge has come back. A counter wrap from 255 to 0 crosses back as a toggle and sets a sticky overflow flag in the system domain. Software clears that flag. In asynchronous mode the oscillator clock must run at least four times slower than the system clock, so that each crossing settles before the next event arrives.

Top module: `tpre_top`

## Requirements
- R1: With `src_async` low the timer domain runs on `sys_clk`; with it high it runs on `osc_clk`, and the counter advances at most once per `osc_clk` period.
- R2: Select code 0 stops the counter: the count holds its value for as long as no count write lands.
- R3: Select code 1 advances the counter by one on every timer-domain clock edge.
- R4: Select codes 2, 3, 4, 5, 6 and 7 advance the counter once every 8, 32, 64, 128, 256 and 1024 timer clocks respectively.
- R5: The divider keeps running while the counter is stopped. `psc_clr`, when high at a timer-clock edge, returns the divider to zero at that edge. With code 2 in force, the first advance then comes on the eighth timer edge after the clearing edge, even if code 2 was written while the counter was stopped.
- R6: A write accepted on `wr_ctl` (code taken from `wr_data[2:0]`) or on `wr_cnt` (all 8 bits) raises the matching busy output on the next `sys_clk` edge. The busy output stays high until the timer domain has taken the value and its acknowledge has returned through a synchronizer. After reset both busy outputs, the flag and the count are zero.
- R7: A write made while the matching busy output is high is dropped; the earlier staged value is the one that lands.
- R8: A count write loads the counter in the timer domain, and a load takes priority over an advance in the same edge.
- R9: A wrap from 255 to 0 sets `ovf_flag`. With the timer domain on `sys_clk` the flag is visible three `sys_clk` edges after the wrapping edge. It stays set until `ovf_clr` is high at a `sys_clk` edge, and a new wrap wins over a clear in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (CPU-side) clock |
| osc_clk | input | 1 | Slow oscillator clock for asynchronous operation |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| src_async | input | 1 | Timer-domain clock source: 0 system, 1 oscillator |
| psc_clr | input | 1 | Divider clear, sampled on the timer-domain clock |
| wr_ctl | input | 1 | Write strobe for the select code |
| wr_cnt | input | 1 | Write strobe for the count value |
| wr_data | input | 8 | Write data; bits 2:0 carry the select code |
| ovf_clr | input | 1 | Clears the overflow flag |
| ctl_busy | output | 1 | Select-code transfer in progress |
| cnt_busy | output | 1 | Count transfer in progress |
| ovf_flag | output | 1 | Sticky overflow flag, system domain |
| tmr_count | output | 8 | Current counter value (timer domain) |

## Verification
The bench builds the block with its default widths: an 8-bit counter and a 10-bit divider. With these values every select code is measured over a whole number of divider periods, including the 1024 ratio, and a wrap is reached in a few hundred cycles. It runs the oscillator at one fifth of the system clock rate. The handshakes are therefore exercised both with a shared clock, where latencies are exact and the flag and divider-clear timing can be checked cycle by cycle, and with a genuinely slower asynchronous clock.

// File: rtl/tpre_pkg.sv
package tpre_pkg;
    localparam int CODE_W    = 3;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] sel_t;

    // divider bits that must all be ones for a tap to fire (ratio = 2**bits)
    function automatic int tap_bits(input int code);
        case (code)
            2:       return 3;
            3:       return 5;
            4:       return 6;
            5:       return 7;
            6:       return 8;
            default: return 10;
        endcase
    endfunction
endpackage

// File: rtl/tpre_sync.sv
module tpre_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tpre_divider.sv
module tpre_divider
    import tpre_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  sel_t sel,
    output logic tick
);
    logic [DIV_W-1:0]     div_d, div_q;
    logic [NUM_CODES-1:0] hit;

    always_comb begin
        div_d = clr ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign hit[0] = 1'b0;
    assign hit[1] = 1'b1;
    for (genvar c = 2; c < NUM_CODES; c++) begin : g_tap
        localparam int BITS = tap_bits(c);
        assign hit[c] = &div_q[BITS-1:0];
    end

    assign tick = hit[sel];
endmodule

// File: rtl/tpre_wrport.sv
module tpre_wrport #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         tmr_clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic         ld,
    output logic [W-1:0] ld_data
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic         req;
        logic         busy;
    } side_t;

    side_t s_d, s_q;
    logic  ack_d, ack_q;
    logic  ack_s;
    logic  req_t;

    tpre_sync #(.W(1)) u_req_sync (
        .clk(tmr_clk), .rst_n(rst_n), .d(s_q.req), .q(req_t)
    );
    tpre_sync #(.W(1)) u_ack_sync (
        .clk(sys_clk), .rst_n(rst_n), .d(ack_q), .q(ack_s)
    );

    // system side: stage, toggle request, wait for matching acknowledge
    always_comb begin
        s_d = s_q;
        if (s_q.busy && (ack_s == s_q.req)) s_d.busy = 1'b0;
        if (wr && !s_q.busy) begin
            s_d.hold = wr_data;
            s_d.req  = ~s_q.req;
            s_d.busy = 1'b1;
        end
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // timer side: one load per request toggle, acknowledge by echoing it
    always_comb begin
        ack_d = req_t;
    end

    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_d;
    end

    assign ld      = (req_t != ack_q);
    assign ld_data = s_q.hold;
    assign busy    = s_q.busy;
endmodule

// File: rtl/tpre_top.sv
module tpre_top
    import tpre_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10
) (
    input  logic             sys_clk,
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             src_async,
    input  logic             psc_clr,
    input  logic             wr_ctl,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf_clr,
    output logic             ctl_busy,
    output logic             cnt_busy,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] tmr_count
);
    typedef struct packed {
        sel_t             sel;
        logic [CNT_W-1:0] count;
        logic             ovf_tgl;
    } tmr_t;

    typedef struct packed {
        logic prev;
        logic flag;
    } flg_t;

    logic             tmr_clk;
    logic             ctl_ld, cnt_ld, tick;
    sel_t             ctl_val, cur_sel;
    logic [CNT_W-1:0] cnt_val;
    logic             ovf_s;
    tmr_t             t_d, t_q;
    flg_t             f_d, f_q;

    assign tmr_clk = src_async ? osc_clk : sys_clk;

    tpre_wrport #(.W(CODE_W)) u_ctl_port (
        .sys_clk(sys_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr(wr_ctl), .wr_data(wr_data[CODE_W-1:0]),
        .busy(ctl_busy), .ld(ctl_ld), .ld_data(ctl_val)
    );

    tpre_wrport #(.W(CNT_W)) u_cnt_port (
        .sys_clk(sys_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr(wr_cnt), .wr_data(wr_data),
        .busy(cnt_busy), .ld(cnt_ld), .ld_data(cnt_val)
    );

    tpre_divider #(.DIV_W(DIV_W)) u_div (
        .clk(tmr_clk), .rst_n(rst_n), .clr(psc_clr),
        .sel(cur_sel), .tick(tick)
    );

    // timer domain: select code, counter, overflow toggle
    always_comb begin
        t_d = t_q;
        if (ctl_ld) t_d.sel = ctl_val;
        if (cnt_ld) begin
            t_d.count = cnt_val;
        end else if (tick) begin
            t_d.count = t_q.count + 1'b1;
            if (&t_q.count) t_d.ovf_tgl = ~t_q.ovf_tgl;
        end
    end

    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    tpre_sync #(.W(1)) u_ovf_sync (
        .clk(sys_clk), .rst_n(rst_n), .d(t_q.ovf_tgl), .q(ovf_s)
    );

    // system domain: sticky flag, a new event beats a clear
    always_comb begin
        f_d      = f_q;
        f_d.prev = ovf_s;
        f_d.flag = (f_q.flag & ~ovf_clr) | (ovf_s != f_q.prev);
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign cur_sel   = t_q.sel;
    assign tmr_count = t_q.count;
    assign ovf_flag  = f_q.flag;
endmodule

// File: rtl/tpre_checker.sv
module tpre_checker
    import tpre_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             sys_clk,
    input logic             tmr_clk,
    input logic             rst_n,
    input logic             wr_ctl,
    input logic             wr_cnt,
    input logic             ctl_busy,
    input logic             cnt_busy,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] tmr_count,
    input logic             cnt_ld,
    input sel_t             cur_sel
);
    AST_CTL_BUSY_SET: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (wr_ctl && !ctl_busy) |=> ctl_busy); // R6

    AST_CNT_BUSY_SET: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (wr_cnt && !cnt_busy) |=> cnt_busy); // R6

    AST_FLAG_CLEAR_ONLY: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(ovf_clr)); // R9

    AST_STOP_HOLD: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (!cnt_ld && cur_sel == '0) |=> $stable(tmr_count)); // R2

    AST_DIRECT_STEP: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (!cnt_ld && cur_sel == sel_t'(1)) |=> (tmr_count == $past(tmr_count) + 1'b1)); // R3

    AST_STEP_MAX_ONE: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (!cnt_ld) |=> (tmr_count == $past(tmr_count) ||
                       tmr_count == $past(tmr_count) + 1'b1)); // R4
endmodule

bind tpre_top tpre_checker #(.CNT_W(CNT_W)) u_chk (
    .sys_clk(sys_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
    .wr_ctl(wr_ctl), .wr_cnt(wr_cnt),
    .ctl_busy(ctl_busy), .cnt_busy(cnt_busy),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .tmr_count(tmr_count), .cnt_ld(cnt_ld), .cur_sel(cur_sel)
);

// File: tb/tpre_top_bench.sv
module tpre_top_bench;
    logic       sys_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_async = 1'b0;
    logic       psc_clr = 1'b0;
    logic       wr_ctl = 1'b0;
    logic       wr_cnt = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ovf_clr = 1'b0;
    logic       ctl_busy, cnt_busy, ovf_flag;
    logic [7:0] tmr_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4  sys_clk = ~sys_clk;
    always #20 osc_clk = ~osc_clk;

    tpre_top u_tpre_top (
        .sys_clk(sys_clk), .osc_clk(osc_clk), .rst_n(rst_n),
        .src_async(src_async), .psc_clr(psc_clr),
        .wr_ctl(wr_ctl), .wr_cnt(wr_cnt), .wr_data(wr_data),
        .ovf_clr(ovf_clr),
        .ctl_busy(ctl_busy), .cnt_busy(cnt_busy),
        .ovf_flag(ovf_flag), .tmr_count(tmr_count)
    );

    localparam int NV = 8;
    localparam logic [2:0] V_SEL [NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd0};
    localparam int V_CYC   [NV] = '{50, 160, 320, 320, 512, 768, 2048, 300};
    localparam int V_DELTA [NV] = '{50, 20, 10, 5, 4, 3, 2, 0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_pulse(input bit is_ctl, input logic [7:0] val);
        @(negedge sys_clk);
        wr_ctl  = is_ctl;
        wr_cnt  = !is_ctl;
        wr_data = val;
        @(negedge sys_clk);
        wr_ctl = 1'b0;
        wr_cnt = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((ctl_busy || cnt_busy) && n < 300) begin
            @(negedge sys_clk);
            n++;
        end
        check(!ctl_busy && !cnt_busy, req, n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] c0, c1;
        int n;

        repeat (3) @(negedge sys_clk);
        rst_n = 1'b1;
        @(negedge sys_clk);
        // R6: reset state
        check(tmr_count == 8'd0, "R6 reset count", tmr_count, 0);
        check(!ctl_busy && !cnt_busy, "R6 reset busy", {ctl_busy, cnt_busy}, 0);
        check(!ovf_flag, "R9 reset flag", ovf_flag, 0);

        // R6: busy raised right after an accepted write
        @(negedge sys_clk);
        wr_ctl = 1'b1; wr_data = 8'd0;
        @(negedge sys_clk);
        wr_ctl = 1'b0;
        check(ctl_busy, "R6 ctl busy after write", ctl_busy, 1);
        wait_idle("R6 ctl busy clears");

        // R8 and R7: stopped counter, second write while busy dropped
        @(negedge sys_clk);
        wr_cnt = 1'b1; wr_data = 8'h10;
        @(negedge sys_clk);
        check(cnt_busy, "R6 cnt busy after write", cnt_busy, 1);
        wr_data = 8'h99;
        @(negedge sys_clk);
        wr_cnt = 1'b0;
        wait_idle("R8 cnt busy clears");
        repeat (4) @(negedge sys_clk);
        check(tmr_count == 8'h10, "R8 R7 count load", tmr_count, 8'h10);

        // R7: select write during busy dropped, code 1 lands
        @(negedge sys_clk);
        wr_ctl = 1'b1; wr_data = 8'd1;
        @(negedge sys_clk);
        wr_data = 8'd0;
        @(negedge sys_clk);
        wr_ctl = 1'b0;
        wait_idle("R7 ctl idle");
        c0 = tmr_count;
        repeat (20) @(negedge sys_clk);
        c1 = tmr_count;
        check(8'(c1 - c0) == 8'd20, "R7 first staged code kept", 8'(c1 - c0), 20);

        // R2 R3 R4: rate table
        for (int v = 0; v < NV; v++) begin
            wr_pulse(1'b1, {5'd0, V_SEL[v]});
            wait_idle("R4 ctl idle");
            @(negedge sys_clk);
            c0 = tmr_count;
            repeat (V_CYC[v]) @(negedge sys_clk);
            c1 = tmr_count;
            check(8'(c1 - c0) == 8'(V_DELTA[v]),
                  (V_SEL[v] == 3'd0) ? "R2 stop" : (V_SEL[v] == 3'd1) ? "R3 direct" : "R4 divide",
                  8'(c1 - c0), V_DELTA[v]);
        end

        // R9: wrap timing and clear
        wr_pulse(1'b1, 8'd1);
        wait_idle("R9 ctl idle");
        wr_pulse(1'b0, 8'd200);
        wait_idle("R9 cnt idle");
        @(negedge sys_clk);
        ovf_clr = 1'b1;
        @(negedge sys_clk);
        ovf_clr = 1'b0;
        check(!ovf_flag, "R9 flag cleared", ovf_flag, 0);
        n = 0;
        while (tmr_count != 8'd0 && n < 400) begin
            @(negedge sys_clk);
            n++;
        end
        check(tmr_count == 8'd0, "R9 wrap reached", tmr_count, 0);
        repeat (2) @(negedge sys_clk);
        check(!ovf_flag, "R9 flag not yet at wrap+2", ovf_flag, 0);
        @(negedge sys_clk);
        check(ovf_flag, "R9 flag at wrap+3", ovf_flag, 1);
        repeat (10) @(negedge sys_clk);
        check(ovf_flag, "R9 flag sticky", ovf_flag, 1);

        // R5: divider cleared while stopped, code 2 written afterwards
        wr_pulse(1'b1, 8'd0);
        wait_idle("R5 stop idle");
        @(negedge sys_clk);
        psc_clr = 1'b1;
        @(negedge sys_clk);
        psc_clr = 1'b0;
        c0 = tmr_count;
        wr_ctl = 1'b1; wr_data = 8'd2;
        @(negedge sys_clk);
        wr_ctl = 1'b0;
        repeat (6) @(negedge sys_clk);
        check(tmr_count == c0, "R5 no advance before 8th edge", tmr_count, c0);
        @(negedge sys_clk);
        check(tmr_count == 8'(c0 + 1), "R5 advance on 8th edge", tmr_count, 8'(c0 + 1));

        // R1: asynchronous source
        wr_pulse(1'b1, 8'd0);
        wait_idle("R1 stop idle");
        @(negedge sys_clk);
        src_async = 1'b1;
        wr_pulse(1'b0, 8'h5A);
        wait_idle("R1 async cnt idle");
        repeat (3) @(negedge osc_clk);
        check(tmr_count == 8'h5A, "R1 R8 async load", tmr_count, 8'h5A);
        wr_pulse(1'b1, 8'd1);
        wait_idle("R1 async ctl idle");
        @(negedge osc_clk);
        c0 = tmr_count;
        repeat (10) @(negedge osc_clk);
        c1 = tmr_count;
        check(8'(c1 - c0) == 8'd10, "R1 oscillator rate", 8'(c1 - c0), 10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule